// File: doc/BRIEF.md
# Dual-Write Register File

This block is a small bank of general-purpose registers hung on a shared bus. Two writers and two readers use it at the same time: each write port carries its own address, data word and enable, and each read port carries its own address and returns a data word. The reads are plain multiplexers, so they have no latency. A write is loaded at the rising clock edge.

Each register is a flip-flop word with a load enable. Two address decoders, one per write port, produce a one-hot strobe vector. The two strobes for a register are ORed into its load enable. A two-way data selector sits in front of every register, and the strobe from port A steers it. When both ports name the same register in one cycle, port A's word is therefore stored. A synchronous active-low reset clears the whole bank and overrides both writers.

Top module: `dual_wr_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register becomes 0, even if either write enable is high. After that edge, both read ports return 0 for every address.
- R2: When `wa_en` is 1 at a rising edge, `wa_data` is stored in register `wa_addr`.
- R3: When `wb_en` is 1 at a rising edge, `wb_data` is stored in register `wb_addr`, unless port A writes the same register in that cycle.
- R4: A register that neither enabled port addresses keeps its value across the edge. Data and address on a port whose enable is 0 have no effect.
- R5: When both enables are 1 and `wa_addr` equals `wb_addr`, the register receives `wa_data` and `wb_data` is dropped.
- R6: When both enables are 1 with different addresses, both registers are updated at the same edge.
- R7: A read port shows the value stored before the current edge. A word written at an edge appears on a read port only after that edge, and is never bypassed within the same cycle.
- R8: The two read ports are independent. Each returns the register chosen by its own 2-bit address (0 to 3), and the two ports agree whenever their addresses are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wa_en | input | 1 | Write enable of port A (priority port) |
| wa_addr | input | 2 | Register index for port A |
| wa_data | input | 8 | Write word for port A |
| wb_en | input | 1 | Write enable of port B |
| wb_addr | input | 2 | Register index for port B |
| wb_data | input | 8 | Write word for port B |
| ra_addr | input | 2 | Register index for read port A |
| ra_data | output | 8 | Read word of port A |
| rb_addr | input | 2 | Register index for read port B |
| rb_data | output | 8 | Read word of port B |

## Verification
The assertions assume that all inputs are known, two-state values at every rising edge. They also assume that a read address held for a cycle names the same register, which is true because every 2-bit code selects a real register. The properties compare read data against write-port values from the previous cycle, so they depend on the inputs changing only between edges. The bench drives every input at the falling edge, keeps every address inside the four-entry range, and leaves all inputs stable until after the next rising edge.

// File: rtl/regfile_pkg.sv
// Package: shared sizing defaults for the dual-write register file.
// Assumes the register count is a power of two so that every address code is valid.
package regfile_pkg;
    parameter int unsigned RF_DEPTH = 4;
    parameter int unsigned RF_WIDTH = 8;

    // Identifies which write port supplies a register's next value
    typedef enum logic { SRC_PORT_B = 1'b0, SRC_PORT_A = 1'b1 } wr_src_e;
endpackage

// File: rtl/rf_wr_decoder.sv
// Module: rf_wr_decoder
// Turns one write port's address into a one-hot strobe per register, gated by
// the port's enable. Assumes DEPTH equals 2**AW.
module rf_wr_decoder #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             en,
    input  logic [AW-1:0]    addr,
    output logic [DEPTH-1:0] hit
);
    // One comparator per register: strobe when enabled and the index matches
    for (genvar i = 0; i < DEPTH; i++) begin : g_hit
        assign hit[i] = en && (addr == AW'(i));
    end
endmodule

// File: rtl/rf_reg_cell.sv
// Module: rf_reg_cell
// One storage word with a load enable and a two-way source selector.
// Port A's strobe steers the selector, so port A wins a shared write.
// Assumes a synchronous, active-low reset.
module rf_reg_cell
    import regfile_pkg::*;
#(
    parameter int unsigned W = RF_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_a,
    input  logic         ld_b,
    input  logic [W-1:0] d_a,
    input  logic [W-1:0] d_b,
    output logic [W-1:0] q
);
    wr_src_e      src;
    logic [W-1:0] next_word;
    logic         load;

    // Select the source: port A whenever its strobe is set
    always_comb begin
        src       = ld_a ? SRC_PORT_A : SRC_PORT_B;
        next_word = (src == SRC_PORT_A) ? d_a : d_b;
        load      = ld_a | ld_b;
    end

    // Storage: reset clears, otherwise load on enable, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= next_word;
    end
endmodule

// File: rtl/rf_rd_mux.sv
// Module: rf_rd_mux
// Combinational read port: returns the word of the register picked by addr.
// Assumes DEPTH equals 2**AW so that every code selects a register.
module rf_rd_mux #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    parameter int unsigned W     = regfile_pkg::RF_WIDTH,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][W-1:0] regs,
    input  logic [AW-1:0]           addr,
    output logic [W-1:0]            data
);
    // Index into the register vector
    always_comb data = regs[addr];
endmodule

// File: rtl/dual_wr_regfile.sv
// Module: dual_wr_regfile
// Register bank with two write ports (A has priority) and two combinational
// read ports. Writes land at the rising edge. Reads show pre-edge contents.
// Assumes a synchronous, active-low reset and DEPTH equal to a power of two.
module dual_wr_regfile
    import regfile_pkg::*;
#(
    parameter int unsigned DEPTH = RF_DEPTH,
    parameter int unsigned W     = RF_WIDTH,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [W-1:0]  wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [W-1:0]  wb_data,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data
);
    logic [DEPTH-1:0]        hit_a;
    logic [DEPTH-1:0]        hit_b;
    logic [DEPTH-1:0][W-1:0] bank;

    rf_wr_decoder #(.DEPTH(DEPTH)) u_dec_a (.en(wa_en), .addr(wa_addr), .hit(hit_a));
    rf_wr_decoder #(.DEPTH(DEPTH)) u_dec_b (.en(wb_en), .addr(wb_addr), .hit(hit_b));

    // One storage cell per register
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        rf_reg_cell #(.W(W)) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .ld_a (hit_a[i]),
            .ld_b (hit_b[i]),
            .d_a  (wa_data),
            .d_b  (wb_data),
            .q    (bank[i])
        );
    end

    rf_rd_mux #(.DEPTH(DEPTH), .W(W)) u_rd_a (.regs(bank), .addr(ra_addr), .data(ra_data));
    rf_rd_mux #(.DEPTH(DEPTH), .W(W)) u_rd_b (.regs(bank), .addr(rb_addr), .data(rb_data));
endmodule

// File: rtl/dual_wr_regfile_chk.sv
// Module: dual_wr_regfile_chk
// Port-level properties of the register file, bound to every instance.
module dual_wr_regfile_chk #(
    parameter int unsigned DEPTH = regfile_pkg::RF_DEPTH,
    parameter int unsigned W     = regfile_pkg::RF_WIDTH,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wa_en,
    input logic [AW-1:0] wa_addr,
    input logic [W-1:0]  wa_data,
    input logic          wb_en,
    input logic [AW-1:0] wb_addr,
    input logic [W-1:0]  wb_data,
    input logic [AW-1:0] ra_addr,
    input logic [W-1:0]  ra_data,
    input logic [AW-1:0] rb_addr,
    input logic [W-1:0]  rb_data
);
    // R1: the cycle after a reset edge, every read returns zero
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (ra_data == '0 && rb_data == '0));

    // R2 and R5: a port A write is visible next cycle, whatever port B did
    a_r2_port_a_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wa_en) && ra_addr == $past(wa_addr))
        |-> ra_data == $past(wa_data));

    // R3: a port B write is visible next cycle unless port A took the same register
    a_r3_port_b_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wb_en) && rb_addr == $past(wb_addr)
         && !($past(wa_en) && $past(wa_addr) == $past(wb_addr)))
        |-> rb_data == $past(wb_data));

    // R4: an untouched register read at a held address keeps its value
    a_r4_hold_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ra_addr == $past(ra_addr)
         && !($past(wa_en) && $past(wa_addr) == ra_addr)
         && !($past(wb_en) && $past(wb_addr) == ra_addr))
        |-> $stable(ra_data));

    // R8: both read ports agree on a shared address
    a_r8_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == rb_addr) |-> (ra_data == rb_data));
endmodule

bind dual_wr_regfile dual_wr_regfile_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data)
);

// File: tb/dual_wr_regfile_test.sv
// Bench: walks a stimulus table against a reference array, then runs directed
// reset and hold tests.
module dual_wr_regfile_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wa_en = 1'b0, wb_en = 1'b0;
    logic [1:0] wa_addr = '0, wb_addr = '0, ra_addr = '0, rb_addr = '0;
    logic [7:0] wa_data = '0, wb_data = '0;
    logic [7:0] ra_data, rb_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [4];

    always #2 clk = ~clk;   // 250 MHz

    dual_wr_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data)
    );

    // Fields: wa_en, wa_addr, wa_data, wb_en, wb_addr, wb_data, ra_addr, rb_addr, req id
    localparam int NV = 12;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 2'd0, 8'h11, 1'b0, 2'd0, 8'h00, 2'd0, 2'd1, 4'd2},
        {1'b0, 2'd0, 8'h00, 1'b1, 2'd1, 8'h22, 2'd0, 2'd1, 4'd3},
        {1'b1, 2'd2, 8'h33, 1'b1, 2'd3, 8'h44, 2'd1, 2'd2, 4'd6},
        {1'b1, 2'd1, 8'h55, 1'b1, 2'd1, 8'h66, 2'd1, 2'd1, 4'd5},
        {1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 2'd1, 2'd2, 4'd5},
        {1'b1, 2'd3, 8'h77, 1'b0, 2'd0, 8'h00, 2'd3, 2'd3, 4'd7},
        {1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 2'd3, 2'd0, 4'd7},
        {1'b0, 2'd0, 8'hFF, 1'b1, 2'd0, 8'h88, 2'd0, 2'd2, 4'd4},
        {1'b0, 2'd2, 8'hEE, 1'b0, 2'd2, 8'hDD, 2'd0, 2'd2, 4'd4},
        {1'b1, 2'd2, 8'hAA, 1'b1, 2'd2, 8'hBB, 2'd2, 2'd2, 4'd5},
        {1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 2'd2, 2'd3, 4'd6},
        {1'b0, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 2'd1, 2'd0, 4'd8}
    };

    function automatic string req_name(int id);
        case (id)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one edge to the reference array: reset first, then B, then A (A wins)
    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) model[i] = 8'h00;
        end else begin
            if (wb_en) model[wb_addr] = wb_data;
            if (wa_en) model[wa_addr] = wa_data;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 8'h00;
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;

        // R1: reset state on every address through both ports
        for (int a = 0; a < 4; a++) begin
            ra_addr = 2'(a); rb_addr = 2'(3 - a);
            #1;
            check("R1", "reset value port A", ra_data, 8'h00);
            check("R1", "reset value port B", rb_data, 8'h00);
        end

        // Table walk: check pre-edge reads (R7), then clock in the writes
        for (int v = 0; v < NV; v++) begin
            {wa_en, wa_addr, wa_data, wb_en, wb_addr, wb_data, ra_addr, rb_addr} = VEC[v][29:4];
            #1;
            check(req_name(int'(VEC[v][3:0])), "read port A", ra_data, model[ra_addr]);
            check(req_name(int'(VEC[v][3:0])), "read port B", rb_data, model[rb_addr]);
            step();
        end
        wa_en = 1'b0; wb_en = 1'b0;

        // R5 and R6: final contents after collisions and parallel writes
        for (int a = 0; a < 4; a++) begin
            ra_addr = 2'(a); rb_addr = 2'(a);
            #1;
            check("R5", "final contents port A", ra_data, model[a]);
            check("R8", "final contents port B", rb_data, model[a]);
        end

        // R4: disabled ports toggling address and data leave every register alone
        for (int k = 0; k < 4; k++) begin
            wa_addr = 2'(k); wa_data = 8'(8'hC0 + k);
            wb_addr = 2'(3 - k); wb_data = 8'(8'h30 + k);
            step();
        end
        for (int a = 0; a < 4; a++) begin
            ra_addr = 2'(a); rb_addr = 2'(a);
            #1;
            check("R4", "hold with enables low", ra_data, model[a]);
        end

        // R7: same-cycle read of a register being written shows the old word
        wa_en = 1'b1; wa_addr = 2'd0; wa_data = 8'h5A; ra_addr = 2'd0;
        #1;
        check("R7", "read during write", ra_data, model[0]);
        step();
        wa_en = 1'b0;
        #1;
        check("R7", "read after write", ra_data, 8'h5A);

        // R1: reset overrides both enabled writers
        rst_n = 1'b0;
        wa_en = 1'b1; wa_addr = 2'd1; wa_data = 8'hA5;
        wb_en = 1'b1; wb_addr = 2'd2; wb_data = 8'h3C;
        step();
        rst_n = 1'b1; wa_en = 1'b0; wb_en = 1'b0;
        for (int a = 0; a < 4; a++) begin
            ra_addr = 2'(a); rb_addr = 2'(a);
            #1;
            check("R1", "reset over writes port A", ra_data, 8'h00);
            check("R1", "reset over writes port B", rb_data, 8'h00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule